// File: doc/BRIEF.md
# Page Way Predictor for a Set-Associative Page Cache

This block guesses which of the four ways of a set holds a requested page, so that a cache controller can issue the data read for that way immediately behind the tag read instead of waiting for the tag compare. It holds no tags and no valid state. It keeps one 2-bit way number per table slot. The slot is selected by XOR-folding the page-granular address down to the table index width. All blocks of one page therefore share one slot, and unrelated pages whose folds collide share it too.

The controller presents the page address on the lookup port and reads the guessed way in the same cycle. Once the tags have been compared, or once a new page has been placed, the controller reports the real way on the resolve port. The slot is rewritten with that way. For a resolve of a resident page, the block raises a one-cycle mismatch flag if the slot held a different way, which tells the controller to re-read the right way from the still-open row. The index is 12 bits wide by default (4096 slots). A parameter widens it to 16 bits (65536 slots) for large caches.

Top module: `way_predictor`

## Requirements
- R1: The table index is the XOR of the page address cut into consecutive index-width chunks starting at bit 0. The highest chunk is zero-extended. The index width is 12 when LARGE_MAP is 0 and 16 when LARGE_MAP is 1.
- R2: `pred_way` is a 2-bit way number (0 to 3). In the same cycle, without any register on the path, it equals the slot selected by `pred_page`.
- R3: Two page addresses with equal fold results read and write the same slot. Pages with different fold results do not affect each other.
- R4: When `res_valid` is 1 at a rising clock edge, the slot selected by `res_page` takes `res_way`. A lookup of that slot during the resolve cycle still returns the previous value, and lookups from the next cycle on return the new value.
- R5: `mismatch` is 1 during the cycle after a resolve with `res_valid`=1 and `res_fill`=0 whose `res_way` differs from the slot's value before that resolve. It is 0 in every other cycle.
- R6: A resolve with `res_fill`=1 (new page placement) writes the slot like any resolve but never raises `mismatch`.
- R7: While `rst_n` is 0, every slot reads way 0 and `mismatch` is 0, taking effect without a clock edge. After `rst_n` rises, the block accepts resolves from the third rising edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| pred_page | input | PAGE_W | Page address to predict |
| pred_way | output | 2 | Predicted way for `pred_page` |
| res_valid | input | 1 | Resolve strobe: the real way of `res_page` is known |
| res_fill | input | 1 | 1 when the resolve is a new page placement rather than a hit |
| res_page | input | PAGE_W | Page address being resolved |
| res_way | input | 2 | Real way of `res_page` |
| mismatch | output | 1 | One-cycle flag: a resolved hit disagreed with the stored way |

## Verification
A wrong slot value appears at `pred_way` in the same cycle that any page folding to that slot is looked up. A wrong fold shows up as a wrong or missing alias between two pages, for example when a bit in the zero-padded top chunk fails to cancel a bit at the same position in the lowest chunk. Both kinds of fault can also appear one cycle after a resolve, as an unexpected or missing `mismatch` pulse. Because of this, the reference table is compared against `pred_way` every cycle and against `mismatch` one cycle after every resolve. Directed alias pairs across all three chunks are included.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = $clog2(WAYS);
  typedef logic [WAY_W-1:0] way_t;

  function automatic int index_width(input bit large_map,
                                     input int small_w,
                                     input int large_w);
    return large_map ? large_w : small_w;
  endfunction
endpackage

// File: rtl/wp_reset_sync.sv
module wp_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic stage_d;
  logic out_d;

  always_comb begin
    stage_d = 1'b1;
    out_d   = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= stage_d;
      rst_sync_n <= out_d;
    end
  end
endmodule

// File: rtl/wp_fold_hash.sv
module wp_fold_hash #(
  parameter int PAGE_W = 30,
  parameter int IDX_W  = 12
) (
  input  logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx
);
  localparam int NCHUNK = (PAGE_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] acc [NCHUNK];

  assign padded = PAD_W'(page);
  assign acc[0] = padded[IDX_W-1:0];

  // XOR chain over the remaining chunks; the top chunk is zero-extended.
  for (genvar c = 1; c < NCHUNK; c++) begin : g_fold
    assign acc[c] = acc[c-1] ^ padded[c*IDX_W +: IDX_W];
  end

  assign idx = acc[NCHUNK-1];
endmodule

// File: rtl/wp_way_table.sv
module wp_way_table
  import wp_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output way_t             rd_a_way,
  input  logic [IDX_W-1:0] rd_b_idx,
  output way_t             rd_b_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  way_t             wr_way
);
  localparam int DEPTH = 1 << IDX_W;

  way_t slot_q [DEPTH];

  assign rd_a_way = slot_q[rd_a_idx];
  assign rd_b_way = slot_q[rd_b_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (wr_en) begin
      slot_q[wr_idx] <= wr_way;
    end
  end
endmodule

// File: rtl/wp_mismatch_flag.sv
module wp_mismatch_flag
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic res_valid,
  input  logic res_fill,
  input  way_t stored_way,
  input  way_t res_way,
  output logic mismatch
);
  logic flag_d;

  always_comb begin
    flag_d = res_valid && !res_fill && (stored_way != res_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mismatch <= 1'b0;
    else        mismatch <= flag_d;
  end
endmodule

// File: rtl/way_predictor.sv
module way_predictor
  import wp_pkg::*;
#(
  parameter int PAGE_W      = 30,
  parameter bit LARGE_MAP   = 1'b0,
  parameter int SMALL_IDX_W = 12,
  parameter int LARGE_IDX_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] pred_page,
  output logic [1:0]        pred_way,
  input  logic              res_valid,
  input  logic              res_fill,
  input  logic [PAGE_W-1:0] res_page,
  input  logic [1:0]        res_way,
  output logic              mismatch
);
  localparam int IDX_W = index_width(LARGE_MAP, SMALL_IDX_W, LARGE_IDX_W);

  logic             rst_sync_n;
  logic [IDX_W-1:0] pred_idx;
  logic [IDX_W-1:0] res_idx;
  way_t             stored_way;
  way_t             lookup_way;
  logic             wr_en;

  wp_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wp_fold_hash #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_hash_pred (
    .page (pred_page),
    .idx  (pred_idx)
  );

  wp_fold_hash #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_hash_res (
    .page (res_page),
    .idx  (res_idx)
  );

  assign wr_en = res_valid;

  wp_way_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_a_idx (pred_idx),
    .rd_a_way (lookup_way),
    .rd_b_idx (res_idx),
    .rd_b_way (stored_way),
    .wr_en    (wr_en),
    .wr_idx   (res_idx),
    .wr_way   (res_way)
  );

  assign pred_way = lookup_way;

  wp_mismatch_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .res_valid  (res_valid),
    .res_fill   (res_fill),
    .stored_way (stored_way),
    .res_way    (res_way),
    .mismatch   (mismatch)
  );
endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
  parameter int PAGE_W = 30
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [PAGE_W-1:0] pred_page,
  input logic [1:0]        pred_way,
  input logic              res_valid,
  input logic              res_fill,
  input logic [PAGE_W-1:0] res_page,
  input logic [1:0]        res_way,
  input logic              mismatch
);
  // R2: the prediction is always a defined way number
  a_r2_way_known: assert property (@(posedge clk) disable iff (!rst_ok)
    !$isunknown(pred_way));

  // R4: a resolved page is predicted with its new way on the next cycle
  a_r4_write_seen: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(res_valid) && pred_page == $past(res_page))
    |-> pred_way == $past(res_way));

  // R5: a resolved hit flags exactly when the old prediction was wrong
  a_r5_flag_matches: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(res_valid && !res_fill && pred_page == res_page))
    |-> mismatch == ($past(pred_way) != $past(res_way)));

  // R5: no flag without a resolved hit in the previous cycle
  a_r5_flag_needs_hit: assert property (@(posedge clk) disable iff (!rst_ok)
    mismatch |-> $past(res_valid && !res_fill));

  // R6: placements never flag
  a_r6_fill_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(res_valid && res_fill)) |-> !mismatch);
endmodule

bind way_predictor wp_checker #(.PAGE_W(PAGE_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .pred_page (pred_page),
  .pred_way  (pred_way),
  .res_valid (res_valid),
  .res_fill  (res_fill),
  .res_page  (res_page),
  .res_way   (res_way),
  .mismatch  (mismatch)
);

// File: tb/way_predictor_test.sv
module way_predictor_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W     = 30;
  localparam int IDX_W      = 12;
  localparam int DEPTH      = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PAGE_W-1:0] pred_page;
  logic [1:0]        pred_way;
  logic              res_valid;
  logic              res_fill;
  logic [PAGE_W-1:0] res_page;
  logic [1:0]        res_way;
  logic              mismatch;

  int checks = 0;
  int errors = 0;
  int ref_tab [DEPTH];
  bit exp_mm = 1'b0;
  string mm_tag = "R7";
  int unsigned seed = 32'h1234_5678;
  logic [PAGE_W-1:0] pool [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  way_predictor #(.PAGE_W(PAGE_W)) uut (
    .clk(clk), .rst_n(rst_n), .pred_page(pred_page), .pred_way(pred_way),
    .res_valid(res_valid), .res_fill(res_fill), .res_page(res_page),
    .res_way(res_way), .mismatch(mismatch)
  );

  // Bitwise formulation: index bit k collects every address bit j with j mod IDX_W == k.
  function automatic int ref_hash(input logic [PAGE_W-1:0] p);
    int h = 0;
    for (int j = 0; j < PAGE_W; j++)
      if (p[j]) h = h ^ (1 << (j % IDX_W));
    return h;
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) ref_tab[i] = 0;
    exp_mm = 1'b0;
  endtask

  // One cycle: check last cycle's flag, drive, check same-cycle lookup, advance model.
  task automatic step(input string ptag, input logic [PAGE_W-1:0] pp,
                      input logic rv, input logic rf,
                      input logic [PAGE_W-1:0] rp, input logic [1:0] rw);
    @(negedge clk);
    check(mm_tag, int'(mismatch), int'(exp_mm));
    pred_page = pp; res_valid = rv; res_fill = rf; res_page = rp; res_way = rw;
    #1;
    check(ptag, int'(pred_way), ref_tab[ref_hash(pp)]);
    exp_mm = rv && !rf && (ref_tab[ref_hash(rp)] != int'(rw));
    mm_tag = rf ? "R6" : "R5";
    if (rv) ref_tab[ref_hash(rp)] = int'(rw);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("R7", '0, 1'b0, 1'b0, '0, 2'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PAGE_W-1:0] p, q;
    rst_n = 1'b0; pred_page = '0; res_valid = 1'b0; res_fill = 1'b0;
    res_page = '0; res_way = 2'd0;
    clear_model();
    mm_tag = "R7";
    // R7: in reset every lookup reads way 0 and no flag
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pred_page = PAGE_W'({rnd(), rnd()});
      #1;
      check("R7 reset lookup", int'(pred_way), 0);
      check("R7 reset flag", int'(mismatch), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    p = 30'h0ABC_1234;
    // R4: placement write, same-cycle lookup sees old value
    step("R4 old value in write cycle", p, 1'b1, 1'b1, p, 2'd3);
    step("R4 new value next cycle", p, 1'b0, 1'b0, '0, 2'd0);
    // R5: hit disagreeing with stored way flags; agreeing does not
    step("R5 lookup", p, 1'b1, 1'b0, p, 2'd1);
    step("R5 lookup", p, 1'b1, 1'b0, p, 2'd1);
    step("R5 lookup", p, 1'b0, 1'b0, '0, 2'd0);
    // R6: placement with a different way stays quiet
    step("R6 lookup", p, 1'b1, 1'b1, p, 2'd2);
    step("R6 written", p, 1'b0, 1'b0, '0, 2'd0);

    // R1/R3: aliases across chunk 0/1 and chunk 0 / padded chunk 2
    q = p ^ 30'(1) ^ 30'(1 << 12);
    step("R3 alias chunk1", q, 1'b0, 1'b0, '0, 2'd0);
    check("R3 alias chunk1 reads 2", int'(pred_way), 2);
    q = p ^ 30'(1 << 5) ^ 30'(1 << 29);
    step("R1 alias padded chunk", q, 1'b0, 1'b0, '0, 2'd0);
    check("R1 alias padded chunk reads 2", int'(pred_way), 2);
    q = p ^ 30'(1 << 29);
    step("R3 non-alias", q, 1'b0, 1'b0, '0, 2'd0);
    check("R3 non-alias reads 0", int'(pred_way), 0);
    // R5: hit on an alias page compares against the shared slot
    step("R5 alias hit", p, 1'b1, 1'b0, p ^ 30'(1 << 3) ^ 30'(1 << 15), 2'd2);
    step("R5 alias hit", p, 1'b1, 1'b0, p ^ 30'(1 << 3) ^ 30'(1 << 15), 2'd0);
    step("R4 alias write seen", p, 1'b0, 1'b0, '0, 2'd0);

    // Mixed traffic over a small pool and random pages
    for (int i = 0; i < 16; i++) pool[i] = PAGE_W'({rnd(), rnd()});
    for (int i = 0; i < 4000; i++) begin
      int unsigned a = rnd();
      int unsigned b = rnd();
      logic [PAGE_W-1:0] pp = a[4] ? pool[a[11:8]] : PAGE_W'({a, b});
      logic [PAGE_W-1:0] rp = b[5] ? pool[b[15:12]] : PAGE_W'({b, a});
      step("R2 random lookup", pp, a[20] | a[21], b[22] & b[23], rp, b[25:24]);
    end

    // R7: asynchronous reset mid-run clears a written slot
    step("R4 before reset", pool[0], 1'b1, 1'b1, pool[0], 2'd3);
    step("R4 before reset", pool[0], 1'b0, 1'b0, '0, 2'd0);
    @(negedge clk);
    check(mm_tag, int'(mismatch), int'(exp_mm));
    #2;
    rst_n = 1'b0;
    #1;
    check("R7 async clear", int'(pred_way), 0);
    check("R7 async flag", int'(mismatch), 0);
    clear_model();
    mm_tag = "R7";
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    step("R7 slot zero after reset", pool[0], 1'b1, 1'b0, pool[0], 2'd1);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule